// File: doc/BRIEF.md
# Task-File Disk Controller Emulator

This block is a bus slave that behaves like a small disk controller driven through programmed I/O. Software sees eight byte-wide task-file registers at offsets 0 to 7 and one device-control register at offset 8. It reaches them through a synchronous register bus with a 4-bit address, byte write data, a read strobe and a write strobe. Sector data lives in an internal byte memory of `NUM_SECT` sectors of 512 bytes each. Software programs a sector count, a 28-bit block address and a drive/head byte, then writes a command code. The block goes busy for `LAT` cycles and then opens a 512-byte data window on the data port. This repeats for each sector.

Two commands are decoded: read sectors (0x20) and write sectors (0x30). Any other code fails with an abort status. The controller answers only as drive 0. A command issued while the drive bit selects drive 1 is ignored. One interrupt is raised per transferred sector. A device-control bit can mask the interrupt line, and another bit resets the register state while it is held.

Read data is registered: the value appears on `rdata_o` from the clock edge that samples `rd_i`, and it stays there until the next read.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset, status (offset 7) reads 0x40 (only READY set), error (offset 1) reads 0x00, count and LBA registers read 0x00, drive/head reads 0xA0, and `irq_o` is low.
- R2: The register map is: 2 = sector count, 3/4/5 = LBA bits 7:0/15:8/23:16, 6 = drive/head. Offset 6 reads back as {1, L, 1, D, LBA[27:24]}, where bit 6 is L (block addressing) and bit 4 is D (drive). Bits 7 and 5 always read 1.
- R3: An accepted command write to offset 7 sets BUSY (status bit 7) from the next cycle. After the latency, BUSY clears and DRQ (status bit 3) sets, so status reads 0x48.
- R4: While DRQ is set, each data-port (offset 0) access moves one byte in order within the sector. Read sectors returns the stored bytes; write sectors stores them. After 512 accesses DRQ drops, the count decrements and the LBA increments. The command continues until the count reaches 0.
- R5: When interrupt enable is on, `irq_o` rises once per sector. For read sectors this happens when DRQ sets; for write sectors it happens after the sector's 512th byte. While device-control bit 1 is set, `irq_o` stays low.
- R6: Reading status at offset 7 clears a pending interrupt. Reading offset 8 returns the same status without clearing it.
- R7: A command code other than 0x20/0x30, or a command with L=0, ends with BUSY and DRQ clear, ERROR (status bit 0) set, error register 0x04 (abort, bit 2), and an interrupt.
- R8: A sector with LBA >= `NUM_SECT` ends the command with ERROR set, error register 0x10 (ID not found, bit 4), and an interrupt.
- R9: A command written while D=1 is ignored: status stays 0x40 and no interrupt is raised.
- R10: Data-port accesses while DRQ is clear, or in the direction opposite to the active command, are ignored: memory and the byte position are unchanged, and such reads return 0x00.
- R11: Writes to offsets 1 to 7 while BUSY or DRQ is set are ignored.
- R12: While device-control bit 2 (offset 8) is set, all task-file registers and the sequencer are held at their reset values and any transfer is abandoned.
- R13: BUSY and DRQ are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset (0-7 task file, 8 device control / alternate status) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered on the edge that samples `rd_i` |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Sector transfers are run with directed fills of every sector and with random block addresses, counts and byte contents. Each buffer read is compared byte for byte against a model of the stored data, which separates address or ordering errors from stuck data. The same read path is exercised with interrupts enabled, with interrupts masked, and with a wrong-direction write poked mid-sector, which shows whether the byte position really holds still. Failure paths (bad opcode, CHS mode, address past capacity, drive 1, soft reset mid-transfer) are each checked for their own status, error code and interrupt combination.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int SECT_BYTES = 512;
  localparam int PTR_W      = $clog2(SECT_BYTES);

  localparam logic [7:0] CMD_READ  = 8'h20;
  localparam logic [7:0] CMD_WRITE = 8'h30;
  localparam logic [7:0] ERR_ABRT  = 8'h04;
  localparam logic [7:0] ERR_IDNF  = 8'h10;

  localparam logic [3:0] A_DATA = 4'd0;
  localparam logic [3:0] A_ERR  = 4'd1;
  localparam logic [3:0] A_CNT  = 4'd2;
  localparam logic [3:0] A_LBA0 = 4'd3;
  localparam logic [3:0] A_LBA1 = 4'd4;
  localparam logic [3:0] A_LBA2 = 4'd5;
  localparam logic [3:0] A_HEAD = 4'd6;
  localparam logic [3:0] A_CMD  = 4'd7;
  localparam logic [3:0] A_CTRL = 4'd8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_XFER} sq_state_e;

  // busy, ready, fault, seek, drq, corr, index, error
  function automatic logic [7:0] pack_status(logic busy, logic drq, logic err);
    return {busy, 1'b1, 2'b00, drq, 2'b00, err};
  endfunction
endpackage

// File: rtl/tf_sector_mem.sv
module tf_sector_mem #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/tf_regs.sv
module tf_regs
  import ata_tf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        we_i,
  input  logic [3:0]  waddr_i,
  input  logic [7:0]  wdata_i,
  input  logic        adv_i,
  output logic [7:0]  count_o,
  output logic [27:0] lba_o,
  output logic        lba_mode_o,
  output logic        drv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o    <= '0;
      lba_o      <= '0;
      lba_mode_o <= 1'b0;
      drv_o      <= 1'b0;
    end else if (clr_i) begin
      count_o    <= '0;
      lba_o      <= '0;
      lba_mode_o <= 1'b0;
      drv_o      <= 1'b0;
    end else if (adv_i) begin
      count_o <= count_o - 8'd1;
      lba_o   <= lba_o + 28'd1;
    end else if (we_i) begin
      unique case (waddr_i)
        A_CNT:  count_o       <= wdata_i;
        A_LBA0: lba_o[7:0]    <= wdata_i;
        A_LBA1: lba_o[15:8]   <= wdata_i;
        A_LBA2: lba_o[23:16]  <= wdata_i;
        A_HEAD: begin
          lba_mode_o   <= wdata_i[6];
          drv_o        <= wdata_i[4];
          lba_o[27:24] <= wdata_i[3:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tf_seq.sv
module tf_seq
  import ata_tf_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int LAT      = 8,
  localparam int LAT_W   = $clog2(LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [7:0]       cmd_i,
  input  logic [27:0]      lba_i,
  input  logic             lba_mode_i,
  input  logic [7:0]       count_i,
  input  logic             acc_i,
  input  logic             irq_clr_i,
  output logic             busy_o,
  output logic             drq_o,
  output logic             err_o,
  output logic [7:0]       err_reg_o,
  output logic             dir_wr_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             adv_o,
  output logic             irq_pend_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SECT_BYTES - 1);
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(LAT - 1);

  sq_state_e        state_q;
  logic [LAT_W-1:0] lat_q;
  logic [7:0]       cmd_q;
  logic             lat_done, bad_cmd, out_of_range, irq_set;

  assign lat_done     = (state_q == SQ_WAIT) && (lat_q == '0);
  assign bad_cmd      = !((cmd_q == CMD_READ) || (cmd_q == CMD_WRITE)) || !lba_mode_i;
  assign out_of_range = lba_i >= 28'(NUM_SECT);
  assign adv_o        = (state_q == SQ_XFER) && acc_i && (ptr_o == PTR_LAST);
  // read: irq at window open (or any failure); write: irq once sector is absorbed
  assign irq_set      = (lat_done && (bad_cmd || out_of_range || cmd_q == CMD_READ))
                      || (adv_o && dir_wr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      lat_q      <= '0;
      cmd_q      <= '0;
      busy_o     <= 1'b0;
      drq_o      <= 1'b0;
      err_o      <= 1'b0;
      err_reg_o  <= '0;
      dir_wr_o   <= 1'b0;
      ptr_o      <= '0;
      irq_pend_o <= 1'b0;
    end else if (clr_i) begin
      state_q    <= SQ_IDLE;
      lat_q      <= '0;
      cmd_q      <= '0;
      busy_o     <= 1'b0;
      drq_o      <= 1'b0;
      err_o      <= 1'b0;
      err_reg_o  <= '0;
      dir_wr_o   <= 1'b0;
      ptr_o      <= '0;
      irq_pend_o <= 1'b0;
    end else begin
      irq_pend_o <= irq_set || (irq_pend_o && !irq_clr_i);
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          busy_o    <= 1'b1;
          err_o     <= 1'b0;
          err_reg_o <= '0;
          cmd_q     <= cmd_i;
          lat_q     <= LAT_INIT;
          state_q   <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (lat_q != '0) begin
            lat_q <= lat_q - 1'b1;
          end else begin
            busy_o <= 1'b0;
            if (bad_cmd) begin
              err_o     <= 1'b1;
              err_reg_o <= ERR_ABRT;
              state_q   <= SQ_IDLE;
            end else if (out_of_range) begin
              err_o     <= 1'b1;
              err_reg_o <= ERR_IDNF;
              state_q   <= SQ_IDLE;
            end else begin
              drq_o    <= 1'b1;
              ptr_o    <= '0;
              dir_wr_o <= (cmd_q == CMD_WRITE);
              state_q  <= SQ_XFER;
            end
          end
        end
        SQ_XFER: if (acc_i) begin
          ptr_o <= ptr_o + 1'b1;
          if (ptr_o == PTR_LAST) begin
            drq_o <= 1'b0;
            if (count_i == 8'd1) begin
              state_q <= SQ_IDLE;
            end else begin
              busy_o  <= 1'b1;
              lat_q   <= LAT_INIT;
              state_q <= SQ_WAIT;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import ata_tf_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int LAT      = 8,
  localparam int SEL_W   = $clog2(NUM_SECT),
  localparam int DEPTH   = NUM_SECT * SECT_BYTES,
  localparam int MEM_AW  = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic              nien_q, srst_q;
  logic [7:0]        count;
  logic [27:0]       lba;
  logic              lba_mode, drv;
  logic              busy, drq, err, dir_wr, adv, irq_pend;
  logic [7:0]        err_reg, status, mem_q, rd_val, reg_q;
  logic [PTR_W-1:0]  ptr;
  logic              tf_open, tf_we, start, mem_we, mem_re, acc, irq_clr, sel_mem_q;
  logic [MEM_AW-1:0] mem_addr;

  assign status  = pack_status(busy, drq, err);
  assign tf_open = !busy && !drq && !srst_q;
  assign tf_we   = wr_i && !addr_i[3] && tf_open;
  assign start   = tf_we && (addr_i == A_CMD) && !drv;
  assign mem_we  = wr_i && (addr_i == A_DATA) && drq && dir_wr;
  assign mem_re  = rd_i && (addr_i == A_DATA) && drq && !dir_wr;
  assign acc     = mem_we || mem_re;
  assign irq_clr = (rd_i && (addr_i == A_CMD)) || start;
  assign irq_o   = irq_pend && !nien_q;
  assign mem_addr = {lba[SEL_W-1:0], ptr};

  // device control is writable at any time, including during a transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nien_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_i && (addr_i == A_CTRL)) begin
      nien_q <= wdata_i[1];
      srst_q <= wdata_i[2];
    end
  end

  tf_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_q),
    .we_i       (tf_we),
    .waddr_i    (addr_i),
    .wdata_i    (wdata_i),
    .adv_i      (adv),
    .count_o    (count),
    .lba_o      (lba),
    .lba_mode_o (lba_mode),
    .drv_o      (drv)
  );

  tf_seq #(.NUM_SECT(NUM_SECT), .LAT(LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_q),
    .start_i    (start),
    .cmd_i      (wdata_i),
    .lba_i      (lba),
    .lba_mode_i (lba_mode),
    .count_i    (count),
    .acc_i      (acc),
    .irq_clr_i  (irq_clr),
    .busy_o     (busy),
    .drq_o      (drq),
    .err_o      (err),
    .err_reg_o  (err_reg),
    .dir_wr_o   (dir_wr),
    .ptr_o      (ptr),
    .adv_o      (adv),
    .irq_pend_o (irq_pend)
  );

  tf_sector_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (mem_addr),
    .wdata_i (wdata_i),
    .rdata_o (mem_q)
  );

  always_comb begin
    unique case (addr_i)
      A_ERR:         rd_val = err_reg;
      A_CNT:         rd_val = count;
      A_LBA0:        rd_val = lba[7:0];
      A_LBA1:        rd_val = lba[15:8];
      A_LBA2:        rd_val = lba[23:16];
      A_HEAD:        rd_val = {1'b1, lba_mode, 1'b1, drv, lba[27:24]};
      A_CMD, A_CTRL: rd_val = status;
      default:       rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (rd_i) begin
      reg_q     <= rd_val;
      sel_mem_q <= mem_re;
    end
  end

  assign rdata_o = sel_mem_q ? mem_q : reg_q;
endmodule

// File: rtl/tf_checker.sv
module tf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic       irq_o,
  input logic       busy_i,
  input logic       drq_i,
  input logic       srst_i,
  input logic       nien_i,
  input logic       drv_i,
  input logic [7:0] status_i
);
  p_cmd_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd7 && !busy_i && !drq_i && !srst_i && !drv_i) |=> busy_i);

  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nien_i |-> !irq_o);

  p_alt_keeps_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == 4'd8 && irq_o) |=> irq_o);

  p_drv1_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd7 && !busy_i && !drq_i && drv_i) |=> (!busy_i && !drq_i));

  p_srst_default_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (status_i == 8'h40 && !irq_o));

  p_busy_drq_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && drq_i));
endmodule

bind ata_taskfile_dev tf_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .irq_o    (irq_o),
  .busy_i   (busy),
  .drq_i    (drq),
  .srst_i   (srst_q),
  .nien_i   (nien_q),
  .drv_i    (drv),
  .status_i (status)
);

// File: tb/tb_ata_taskfile_dev.sv
`timescale 1ns/1ps
module tb_ata_taskfile_dev;
  localparam int NS  = 4;
  localparam int LAT = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0, bad = 0;
  logic [7:0] model [NS*512];

  always #5 clk = ~clk;

  ata_taskfile_dev #(.NUM_SECT(NS), .LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_status(logic b, logic d, logic e);
    return {b, 1'b1, 2'b00, d, 2'b00, e};
  endfunction

  function automatic logic [7:0] exp_head(logic l, logic d, logic [3:0] hi);
    return {1'b1, l, 1'b1, d, hi};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic setup(input int lba, input int cnt, input logic [7:0] head);
    bwr(2, 8'(cnt)); bwr(3, 8'(lba)); bwr(4, 8'h00); bwr(5, 8'h00); bwr(6, head);
  endtask

  task automatic wait_ready(output logic [7:0] s);
    for (int i = 0; i < 200; i++) begin
      brd(8, s);
      if (!s[7]) break;
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int lba, input int cnt, input bit probe);
    logic [7:0] s, v, b;
    setup(lba, cnt, 8'hE0);
    bwr(7, 8'h30);
    if (probe) begin
      brd(8, s); chk("R3", "busy after write cmd", s, exp_status(1, 0, 0));
    end
    for (int k = 0; k < cnt; k++) begin
      wait_ready(s);
      chk("R3", "status at write window", s, exp_status(0, 1, 0));
      if (probe && k == 0) begin
        bwr(3, 8'h77); brd(3, v);
        chk("R11", "lba write during DRQ", v, lba);
      end
      for (int i = 0; i < 512; i++) begin
        b = 8'($urandom);
        model[(lba + k) * 512 + i] = b;
        bwr(0, b);
      end
      chk("R5", "irq after written sector", irq, 1);
      brd(7, s);
      chk("R6", "status read clears irq", irq, 0);
    end
    brd(2, v); chk("R4", "count after write", v, 0);
    brd(3, v); chk("R4", "lba after write", v, lba + cnt);
  endtask

  task automatic do_read(input int lba, input int cnt, input bit masked, input bit poke);
    logic [7:0] s, v;
    int errs;
    setup(lba, cnt, 8'hE0);
    bwr(7, 8'h20);
    for (int k = 0; k < cnt; k++) begin
      if (!masked) begin
        wait_irq();
        chk("R5", "irq at read window", irq, 1);
        brd(7, s);
        chk("R3", "status at read window", s, exp_status(0, 1, 0));
      end else begin
        for (int i = 0; i < 200; i++) begin
          brd(7, s);
          if (s[3]) break;
        end
        chk("R5", "masked irq stays low", irq, 0);
      end
      errs = 0;
      for (int i = 0; i < 512; i++) begin
        if (poke && i == 10) bwr(0, 8'hAA);
        brd(0, v);
        if (v !== model[(lba + k) * 512 + i]) errs++;
      end
      chk(poke ? "R10" : "R4", "read sector mismatches", errs, 0);
    end
    brd(7, s); chk("R4", "status after read", s, exp_status(0, 0, 0));
    brd(2, v); chk("R4", "count after read", v, 0);
  endtask

  task automatic err_cmd(input string req, input int lba, input logic [7:0] head,
                         input logic [7:0] cmd, input logic [7:0] exp_err);
    logic [7:0] s, v;
    setup(lba, 1, head);
    bwr(7, cmd);
    wait_irq();
    chk(req, "irq on failed cmd", irq, 1);
    brd(8, s);
    chk("R6", "alt status keeps irq", irq, 1);
    brd(7, s);
    chk(req, "status on failure", s, exp_status(0, 0, 1));
    chk("R6", "irq cleared by status", irq, 0);
    brd(1, v);
    chk(req, "error register", v, exp_err);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] v, s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    chk("R1", "irq after reset", irq, 0);
    brd(7, v); chk("R1", "status", v, 8'h40);
    brd(1, v); chk("R1", "error", v, 8'h00);
    brd(2, v); chk("R1", "count", v, 8'h00);
    brd(3, v); chk("R1", "lba low", v, 8'h00);
    brd(6, v); chk("R1", "head", v, exp_head(0, 0, 4'h0));

    // R2 map and head readback
    bwr(4, 8'h3C); brd(4, v); chk("R2", "lba mid", v, 8'h3C);
    bwr(5, 8'hA5); brd(5, v); chk("R2", "lba high", v, 8'hA5);
    bwr(6, 8'h41); brd(6, v); chk("R2", "head forced bits", v, exp_head(1, 0, 4'h1));

    // R10 idle data port
    brd(0, v); chk("R10", "idle data read", v, 8'h00);

    // fill all sectors, read back
    do_write(0, NS, 1'b1);
    bwr(0, 8'h5A);
    do_read(0, NS, 1'b0, 1'b0);

    // R10 wrong-direction write mid read; R5 masked
    do_read(1, 1, 1'b0, 1'b1);
    bwr(8, 8'h02);
    do_read(2, 2, 1'b1, 1'b0);
    bwr(8, 8'h00);

    // random rounds
    for (int r = 0; r < 5; r++) begin
      int l, c;
      l = int'($urandom % NS);
      c = 1 + int'($urandom % 2);
      if (l + c > NS) c = NS - l;
      do_write(l, c, 1'b0);
      do_read(l, c, 1'b0, 1'b0);
    end

    // R7 / R8 failures
    err_cmd("R7", 0, 8'hE0, 8'hEC, 8'h04);
    err_cmd("R7", 0, 8'hA0, 8'h20, 8'h04);
    err_cmd("R8", NS, 8'hE0, 8'h20, 8'h10);
    do_read(0, 1, 1'b0, 1'b0);
    brd(1, v); chk("R7", "error cleared by new cmd", v, 8'h00);

    // R9 drive 1
    setup(0, 1, 8'hF0);
    bwr(7, 8'h20);
    repeat (LAT + 4) @(negedge clk);
    chk("R9", "no irq for drive 1", irq, 0);
    brd(7, v); chk("R9", "status for drive 1", v, 8'h40);

    // R12 soft reset
    setup(2, 3, 8'hE3);
    bwr(8, 8'h04);
    brd(7, v); chk("R12", "status in reset", v, 8'h40);
    brd(2, v); chk("R12", "count in reset", v, 8'h00);
    brd(6, v); chk("R12", "head in reset", v, exp_head(0, 0, 4'h0));
    bwr(2, 8'h09); brd(2, v); chk("R12", "write held off", v, 8'h00);
    bwr(8, 8'h00);
    setup(0, 2, 8'hE0);
    bwr(7, 8'h20);
    wait_irq();
    bwr(8, 8'h04); bwr(8, 8'h00);
    chk("R12", "irq after mid-transfer reset", irq, 0);
    brd(7, s); chk("R12", "status after mid-transfer reset", s, 8'h40);
    brd(2, v); chk("R12", "count after mid-transfer reset", v, 8'h00);

    report();
  end
endmodule